// File: doc/BRIEF.md
# Operand Fetch Addressing Sequencer

This block gathers the operands of one instruction for an 8-bit processor with a 16-bit address space. The decoder gives it an addressing-mode code, two register selectors with the values the register file holds for them, and the current program counter and HL pair. The sequencer then makes the bus reads that the mode needs. These can be immediate bytes at the program counter, an indirect read through a register, or an absolute address taken from the instruction stream followed by a read at that address. It also works out whether the instruction's result goes to memory and at which address.

The bus has a single port, one byte wide, and uses a request/valid handshake. The sequencer holds `bus_req` and `bus_addr` steady until `bus_rvalid` arrives, so each handshake is one machine cycle. When the fetch ends, `done` pulses for one clock. At that point `data_out`, `dest_addr`, `dest_is_mem`, `pc_out` and `hl_out` are valid, and `hl_upd` tells the register file whether to write HL back.

The controller has five states:
- IDLE: waits for `start`.
- IMM_LO: reads the first stream byte.
- IMM_HI: reads the second stream byte.
- MEM_RD: makes the indirect or absolute data read.
- DONE: produces the one-clock completion pulse.

The transitions are as follows:
- IDLE→DONE for `start` when no bus access is needed. This covers an invalid instruction, register-only modes, HL stores, register-to-memory and illegal codes.
- IDLE→IMM_LO for the immediate and absolute modes.
- IDLE→MEM_RD for the indirect reads.
- IMM_LO→IMM_HI for the modes that need a 16-bit immediate.
- IMM_LO→DONE for the single-byte modes.
- IMM_HI→MEM_RD for the absolute load.
- IMM_HI→DONE for a 16-bit immediate and the absolute store.
- MEM_RD→DONE once the read completes.
- DONE→IDLE always.

Top module: `opfetch_seq`

## Requirements
- R1: On `start`, the destination address clears to 0 and `dest_is_mem` drops. With `inst_valid` low, the fetch makes no bus access, `done` follows in the next cycle, and `data_out` is unchanged.
- R2: Codes 3 (8-bit immediate) and 13 (immediate to memory) read one byte at PC in one bus cycle, give `data_out` = {8'h00, byte} and advance PC by 1. Code 13 also sets the destination to `r1_val` and raises `dest_is_mem`.
- R3: Code 4 (16-bit immediate) reads PC and then PC+1 (16-bit wrap). It gives `data_out` = {second byte, first byte} and advances PC by 2.
- R4: When a selector equals 3'd1 (register C), the indirect address is the register value OR 16'hFF00. This applies to code 5 (register to memory: `data_out` = `r2_val`, destination from `r1_sel`/`r1_val`, `dest_is_mem`=1) and to code 6 (load through `r2_sel`/`r2_val`, one bus cycle).
- R5: Code 11 (high-page store) reads one byte B at PC and sets the destination to {8'hFF, B} with `dest_is_mem`=1. PC advances by 1 and `data_out` is unchanged.
- R6: Codes 7 and 8 read at `r2_val` in one bus cycle. Codes 9 and 10 make no bus access and set `data_out`=`r2_val`, destination `r1_val`, `dest_is_mem`=1. Codes 7 and 9 give `hl_out` = HL+1, codes 8 and 10 give HL−1 (16-bit wrap), and `hl_upd` pulses with `done`.
- R7: Code 15 (absolute load) reads a little-endian address at PC and PC+1 and then reads the byte at that address. This is three bus cycles in total, and PC advances by 2.
- R8: Code 12 (absolute store) takes the 16-bit immediate as the destination with `dest_is_mem`=1, gives `data_out`=`r2_val` and advances PC by 2.
- R9: Code 14 (read-modify-write) reads the byte at `r1_val` into `data_out` and sets the destination to `r1_val` with `dest_is_mem`=1.
- R10: Codes 0, 1 and 2 make no bus access. Code 1 gives `data_out`=`r1_val`, code 2 gives `r2_val`, and code 0 leaves `data_out` unchanged.
- R11: A code of 16 or above, with `inst_valid` high, sets `mode_err`, which stays high until reset. The fetch completes with no bus access.
- R12: `done` is high for exactly one clock, in the cycle after the last handshake (or after `start` when the fetch needs no bus access). `start` while `busy` is ignored. After reset the block is idle with `done`, `bus_req` and `mode_err` low.
- R13: While `bus_req` waits for `bus_rvalid`, `bus_req` and `bus_addr` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a fetch (taken only when idle) |
| inst_valid | input | 1 | A decoded instruction is present |
| mode | input | 5 | Addressing-mode code |
| r1_sel | input | 3 | First register selector |
| r1_val | input | 16 | Value of the first register |
| r2_sel | input | 3 | Second register selector |
| r2_val | input | 16 | Value of the second register |
| pc_in | input | 16 | Program counter at start |
| hl_in | input | 16 | HL pair at start |
| bus_req | output | 1 | Read request |
| bus_addr | output | 16 | Read address |
| bus_rdata | input | 8 | Read data |
| bus_rvalid | input | 1 | Read data valid, completes the handshake |
| busy | output | 1 | A fetch is in progress |
| done | output | 1 | One-clock completion pulse |
| data_out | output | 16 | Fetched operand |
| dest_addr | output | 16 | Memory destination address |
| dest_is_mem | output | 1 | Destination is memory |
| pc_out | output | 16 | Program counter after the fetch |
| hl_out | output | 16 | HL after the fetch |
| hl_upd | output | 1 | HL must be written back (with done) |
| mode_err | output | 1 | Sticky illegal-mode flag |

## Verification
The assertions take for granted that `bus_rvalid` is only raised while `bus_req` is high. They also assume that the register values and selectors stay steady from the `start` cycle until it has been taken. The bench's bus model keeps to this. It raises valid only after it has seen a pending request at a falling edge, it drops valid at the next falling edge, and it inserts zero to two wait cycles. The driver changes its inputs only at falling edges and holds them for the whole fetch.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;

    typedef enum logic [4:0] {
        M_IMP      = 5'd0,
        M_REG1     = 5'd1,
        M_REG2     = 5'd2,
        M_IMM8     = 5'd3,
        M_IMM16    = 5'd4,
        M_REG_MEM  = 5'd5,
        M_LD_IND   = 5'd6,
        M_LD_HLI   = 5'd7,
        M_LD_HLD   = 5'd8,
        M_ST_HLI   = 5'd9,
        M_ST_HLD   = 5'd10,
        M_HIPAGE   = 5'd11,
        M_ABS_ST   = 5'd12,
        M_IMM_MEM  = 5'd13,
        M_RMW      = 5'd14,
        M_ABS_LD   = 5'd15
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_IMM_LO = 3'd1,
        ST_IMM_HI = 3'd2,
        ST_MEM_RD = 3'd3,
        ST_DONE   = 3'd4
    } state_e;

endpackage

// File: rtl/opfetch_hipage.sv
module opfetch_hipage #(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int SEL_W   = 3,
    parameter int SEL_C   = 1,
    parameter int HI_PAGE = 'hFF
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [AW-1:0]    val,
    output logic [AW-1:0]    eff
);
    localparam logic [AW-1:0] PAGE_MASK = AW'(HI_PAGE) << DW;

    // selector naming the page register forces the upper byte
    always_comb begin
        if (sel == SEL_W'(SEL_C)) eff = val | PAGE_MASK;
        else                      eff = val;
    end
endmodule

// File: rtl/opfetch_step.sv
module opfetch_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic         down,
    output logic [W-1:0] res
);
    always_comb begin
        if (down) res = val - W'(1);
        else      res = val + W'(1);
    end
endmodule

// File: rtl/opfetch_seq.sv
module opfetch_seq
    import opfetch_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int MW      = 5,
    parameter int SEL_W   = 3,
    parameter int SEL_C   = 1,
    parameter int HI_PAGE = 'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             inst_valid,
    input  logic [MW-1:0]    mode,
    input  logic [SEL_W-1:0] r1_sel,
    input  logic [AW-1:0]    r1_val,
    input  logic [SEL_W-1:0] r2_sel,
    input  logic [AW-1:0]    r2_val,
    input  logic [AW-1:0]    pc_in,
    input  logic [AW-1:0]    hl_in,
    output logic             bus_req,
    output logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_rdata,
    input  logic             bus_rvalid,
    output logic             busy,
    output logic             done,
    output logic [AW-1:0]    data_out,
    output logic [AW-1:0]    dest_addr,
    output logic             dest_is_mem,
    output logic [AW-1:0]    pc_out,
    output logic [AW-1:0]    hl_out,
    output logic             hl_upd,
    output logic             mode_err
);
    localparam int              UW        = AW - DW;
    localparam logic [AW-1:0]   PAGE_BASE = AW'(HI_PAGE) << DW;

    state_e          state_q, state_d;
    logic [MW-1:0]   mode_q;
    logic [DW-1:0]   lo_q;
    logic [AW-1:0]   addr_q, data_q, dest_q, pc_q, hl_q;
    logic            dmem_q, hlupd_q, err_q;
    logic [AW-1:0]   r1_eff, r2_eff, hl_next, pc_next;
    logic            hl_down, hs;

    opfetch_hipage #(.AW(AW), .DW(DW), .SEL_W(SEL_W), .SEL_C(SEL_C), .HI_PAGE(HI_PAGE))
        u_page1 (.sel(r1_sel), .val(r1_val), .eff(r1_eff));
    opfetch_hipage #(.AW(AW), .DW(DW), .SEL_W(SEL_W), .SEL_C(SEL_C), .HI_PAGE(HI_PAGE))
        u_page2 (.sel(r2_sel), .val(r2_val), .eff(r2_eff));

    assign hl_down = (mode == MW'(M_LD_HLD)) || (mode == MW'(M_ST_HLD));
    opfetch_step #(.W(AW)) u_hl_step (.val(hl_in), .down(hl_down), .res(hl_next));
    opfetch_step #(.W(AW)) u_pc_step (.val(pc_q),  .down(1'b0),    .res(pc_next));

    assign hs = bus_req && bus_rvalid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (!inst_valid) state_d = ST_DONE;
                    else begin
                        case (mode)
                            MW'(M_IMM8), MW'(M_IMM16), MW'(M_HIPAGE),
                            MW'(M_ABS_ST), MW'(M_IMM_MEM), MW'(M_ABS_LD):
                                state_d = ST_IMM_LO;
                            MW'(M_LD_IND), MW'(M_LD_HLI), MW'(M_LD_HLD), MW'(M_RMW):
                                state_d = ST_MEM_RD;
                            default:
                                state_d = ST_DONE;
                        endcase
                    end
                end
            end
            ST_IMM_LO: begin
                if (hs) begin
                    if (mode_q == MW'(M_IMM16) || mode_q == MW'(M_ABS_LD) ||
                        mode_q == MW'(M_ABS_ST))
                        state_d = ST_IMM_HI;
                    else
                        state_d = ST_DONE;
                end
            end
            ST_IMM_HI: begin
                if (hs) state_d = (mode_q == MW'(M_ABS_LD)) ? ST_MEM_RD : ST_DONE;
            end
            ST_MEM_RD: begin
                if (hs) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            lo_q    <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            dest_q  <= '0;
            dmem_q  <= 1'b0;
            pc_q    <= '0;
            hl_q    <= '0;
            hlupd_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q  <= mode;
                        dest_q  <= '0;
                        dmem_q  <= 1'b0;
                        pc_q    <= pc_in;
                        hl_q    <= hl_in;
                        hlupd_q <= 1'b0;
                        if (inst_valid) begin
                            case (mode)
                                MW'(M_REG1): data_q <= r1_val;
                                MW'(M_REG2): data_q <= r2_val;
                                MW'(M_REG_MEM): begin
                                    data_q <= r2_val;
                                    dest_q <= r1_eff;
                                    dmem_q <= 1'b1;
                                end
                                MW'(M_LD_IND): addr_q <= r2_eff;
                                MW'(M_LD_HLI), MW'(M_LD_HLD): begin
                                    addr_q  <= r2_val;
                                    hl_q    <= hl_next;
                                    hlupd_q <= 1'b1;
                                end
                                MW'(M_ST_HLI), MW'(M_ST_HLD): begin
                                    data_q  <= r2_val;
                                    dest_q  <= r1_val;
                                    dmem_q  <= 1'b1;
                                    hl_q    <= hl_next;
                                    hlupd_q <= 1'b1;
                                end
                                MW'(M_ABS_ST): data_q <= r2_val;
                                MW'(M_IMM_MEM): begin
                                    dest_q <= r1_val;
                                    dmem_q <= 1'b1;
                                end
                                MW'(M_RMW): begin
                                    addr_q <= r1_val;
                                    dest_q <= r1_val;
                                    dmem_q <= 1'b1;
                                end
                                MW'(M_IMP), MW'(M_IMM8), MW'(M_IMM16),
                                MW'(M_HIPAGE), MW'(M_ABS_LD): ;
                                default: err_q <= 1'b1;
                            endcase
                        end
                    end
                end
                ST_IMM_LO: begin
                    if (hs) begin
                        pc_q <= pc_next;
                        case (mode_q)
                            MW'(M_IMM8), MW'(M_IMM_MEM):
                                data_q <= {{UW{1'b0}}, bus_rdata};
                            MW'(M_HIPAGE): begin
                                dest_q <= PAGE_BASE | {{UW{1'b0}}, bus_rdata};
                                dmem_q <= 1'b1;
                            end
                            default: lo_q <= bus_rdata;
                        endcase
                    end
                end
                ST_IMM_HI: begin
                    if (hs) begin
                        pc_q <= pc_next;
                        case (mode_q)
                            MW'(M_IMM16): data_q <= {bus_rdata, lo_q};
                            MW'(M_ABS_ST): begin
                                dest_q <= {bus_rdata, lo_q};
                                dmem_q <= 1'b1;
                            end
                            default: addr_q <= {bus_rdata, lo_q};
                        endcase
                    end
                end
                ST_MEM_RD: begin
                    if (hs) data_q <= {{UW{1'b0}}, bus_rdata};
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_req  = (state_q == ST_IMM_LO) || (state_q == ST_IMM_HI) || (state_q == ST_MEM_RD);
        bus_addr = (state_q == ST_MEM_RD) ? addr_q : pc_q;
    end

    assign busy        = (state_q != ST_IDLE);
    assign done        = (state_q == ST_DONE);
    assign data_out    = data_q;
    assign dest_addr   = dest_q;
    assign dest_is_mem = dmem_q;
    assign pc_out      = pc_q;
    assign hl_out      = hl_q;
    assign hl_upd      = hlupd_q && (state_q == ST_DONE);
    assign mode_err    = err_q;

    // R12: completion pulse lasts one clock
    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13: a pending request holds its address
    a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_rvalid) |=> (bus_req && $stable(bus_addr)));

    // R5: high-page store lands in the top page
    a_r5_hipage_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IMM_LO && mode_q == MW'(M_HIPAGE) && hs)
        |=> (dest_addr[AW-1:DW] == UW'(HI_PAGE) && dest_is_mem));

    // R2: each stream byte advances the program counter by one
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IMM_LO || state_q == ST_IMM_HI) && hs)
        |=> (pc_out == $past(pc_out) + AW'(1)));

    // R11: illegal-mode flag is sticky
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |=> mode_err);

    // R10: register-only modes never request the bus
    a_r10_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && inst_valid && mode <= MW'(M_REG2))
        |=> (!bus_req && done));

    // R12: start while busy does not restart the fetch
    a_r12_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(mode_q) && busy));
endmodule

// File: tb/opfetch_seq_bench.sv
module opfetch_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, inst_valid = 1'b0;
    logic [4:0]  mode = '0;
    logic [2:0]  r1_sel = '0, r2_sel = '0;
    logic [15:0] r1_val = '0, r2_val = '0, pc_in = '0, hl_in = '0;
    logic        bus_req, busy, done, dest_is_mem, hl_upd, mode_err;
    logic [15:0] bus_addr, data_out, dest_addr, pc_out, hl_out;
    logic [7:0]  bus_rdata = '0;
    logic        bus_rvalid = 1'b0;

    always #5 clk = ~clk;

    opfetch_seq u_opfetch_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .inst_valid(inst_valid), .mode(mode),
        .r1_sel(r1_sel), .r1_val(r1_val), .r2_sel(r2_sel), .r2_val(r2_val),
        .pc_in(pc_in), .hl_in(hl_in), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .busy(busy), .done(done),
        .data_out(data_out), .dest_addr(dest_addr), .dest_is_mem(dest_is_mem),
        .pc_out(pc_out), .hl_out(hl_out), .hl_upd(hl_upd), .mode_err(mode_err));

    typedef struct {
        string       tag;
        logic [15:0] data, dest, pc, hl;
        logic        mem, hu, err;
        int          nbus;
        logic [15:0] a0, a1, a2;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0, fails = 0, n_done = 0, lat_cfg = 0, wcnt = 0, nseen = 0;
    logic [15:0] seen[4];
    logic [15:0] rv_addr = '0;
    logic        prev_done = 1'b0;
    logic [15:0] prev_data = '0;
    logic        exp_err = 1'b0;
    int          cyc = 0;

    function automatic logic [7:0] mem_at(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // bus responder and scoreboard monitor, in this order at each falling edge
    always @(negedge clk) begin
        if (bus_rvalid) begin
            if (nseen < 4) seen[nseen] = rv_addr;
            nseen++;
            bus_rvalid = 1'b0;
        end
        if (bus_req && !bus_rvalid) begin
            if (wcnt >= lat_cfg) begin
                bus_rvalid = 1'b1;
                rv_addr    = bus_addr;
                bus_rdata  = mem_at(bus_addr);
                wcnt       = 0;
            end else wcnt++;
        end
        if (rst_n) begin
            if (done) begin
                checks++;
                if (prev_done) begin
                    fails++;
                    $display("FAIL R12 done held: actual 2 cycles expected 1");
                end
                checks++;
                if (sb.size() == 0) begin
                    fails++;
                    $display("FAIL R12 unexpected done: actual done expected none");
                end else begin
                    exp_t e;
                    logic ok;
                    e  = sb.pop_front();
                    ok = (data_out == e.data) && (dest_addr == e.dest) &&
                         (dest_is_mem == e.mem) && (pc_out == e.pc) && (hl_out == e.hl) &&
                         (hl_upd == e.hu) && (mode_err == e.err) && (nseen == e.nbus);
                    if (ok && e.nbus > 0) ok = (seen[0] == e.a0);
                    if (ok && e.nbus > 1) ok = (seen[1] == e.a1);
                    if (ok && e.nbus > 2) ok = (seen[2] == e.a2);
                    if (!ok) begin
                        fails++;
                        $display("FAIL %s: actual data=%h dest=%h mem=%b pc=%h hl=%h hu=%b err=%b nbus=%0d a0=%h expected data=%h dest=%h mem=%b pc=%h hl=%h hu=%b err=%b nbus=%0d a0=%h",
                            e.tag, data_out, dest_addr, dest_is_mem, pc_out, hl_out, hl_upd,
                            mode_err, nseen, seen[0], e.data, e.dest, e.mem, e.pc, e.hl,
                            e.hu, e.err, e.nbus, e.a0);
                    end
                end
                n_done++;
            end
            prev_done = done;
        end
    end

    task automatic fetch(input int m, input logic v, input logic [2:0] s1, input logic [15:0] v1,
                         input logic [2:0] s2, input logic [15:0] v2, input logic [15:0] pc,
                         input logic [15:0] hl, input int lat, input bit poke, input string tag);
        exp_t e;
        logic [15:0] ad;
        int target;
        e.tag = tag; e.data = prev_data; e.dest = '0; e.mem = 1'b0; e.pc = pc; e.hl = hl;
        e.hu = 1'b0; e.nbus = 0; e.a0 = '0; e.a1 = '0; e.a2 = '0;
        if (v) begin
            case (m)
                0: ;
                1: e.data = v1;
                2: e.data = v2;
                3, 13: begin
                    e.data = {8'h00, mem_at(pc)}; e.nbus = 1; e.a0 = pc; e.pc = pc + 16'd1;
                    if (m == 13) begin e.dest = v1; e.mem = 1'b1; end
                end
                4: begin
                    e.data = {mem_at(pc + 16'd1), mem_at(pc)}; e.nbus = 2;
                    e.a0 = pc; e.a1 = pc + 16'd1; e.pc = pc + 16'd2;
                end
                5: begin
                    e.data = v2; e.dest = (s1 == 3'd1) ? (v1 | 16'hFF00) : v1; e.mem = 1'b1;
                end
                6: begin
                    ad = (s2 == 3'd1) ? (v2 | 16'hFF00) : v2;
                    e.data = {8'h00, mem_at(ad)}; e.nbus = 1; e.a0 = ad;
                end
                7, 8: begin
                    e.data = {8'h00, mem_at(v2)}; e.nbus = 1; e.a0 = v2; e.hu = 1'b1;
                    e.hl = (m == 7) ? hl + 16'd1 : hl - 16'd1;
                end
                9, 10: begin
                    e.data = v2; e.dest = v1; e.mem = 1'b1; e.hu = 1'b1;
                    e.hl = (m == 9) ? hl + 16'd1 : hl - 16'd1;
                end
                11: begin
                    e.dest = {8'hFF, mem_at(pc)}; e.mem = 1'b1; e.nbus = 1; e.a0 = pc;
                    e.pc = pc + 16'd1;
                end
                12: begin
                    e.dest = {mem_at(pc + 16'd1), mem_at(pc)}; e.mem = 1'b1; e.data = v2;
                    e.nbus = 2; e.a0 = pc; e.a1 = pc + 16'd1; e.pc = pc + 16'd2;
                end
                14: begin
                    e.data = {8'h00, mem_at(v1)}; e.dest = v1; e.mem = 1'b1;
                    e.nbus = 1; e.a0 = v1;
                end
                15: begin
                    ad = {mem_at(pc + 16'd1), mem_at(pc)};
                    e.data = {8'h00, mem_at(ad)}; e.nbus = 3;
                    e.a0 = pc; e.a1 = pc + 16'd1; e.a2 = ad; e.pc = pc + 16'd2;
                end
                default: exp_err = 1'b1;
            endcase
        end
        e.err = exp_err;
        prev_data = e.data;
        sb.push_back(e);
        target = n_done + 1;
        @(negedge clk);
        lat_cfg = lat; nseen = 0;
        mode = 5'(m); inst_valid = v; r1_sel = s1; r1_val = v1; r2_sel = s2; r2_val = v2;
        pc_in = pc; hl_in = hl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            start = 1'b1; mode = 5'd0;
            @(negedge clk);
            start = 1'b0; mode = 5'(m);
        end
        while (n_done < target) @(negedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (done || busy || bus_req || mode_err || data_out != 0 || dest_addr != 0) begin
            fails++;
            $display("FAIL R12 reset state: actual done=%b busy=%b req=%b err=%b expected all 0",
                     done, busy, bus_req, mode_err);
        end
        fetch(5, 1, 3'd2, 16'h1234, 3'd4, 16'h00AB, 16'h0100, 16'h8000, 0, 0, "R4 reg to mem plain");
        fetch(0, 0, 3'd2, 16'h1234, 3'd4, 16'h0055, 16'h0100, 16'h8000, 0, 0, "R1 no instruction");
        fetch(0, 1, 3'd0, 16'h1111, 3'd0, 16'h2222, 16'h0200, 16'h8000, 0, 0, "R10 implied");
        fetch(1, 1, 3'd0, 16'h1111, 3'd0, 16'h2222, 16'h0200, 16'h8000, 0, 0, "R10 reg1");
        fetch(2, 1, 3'd0, 16'h1111, 3'd0, 16'h2222, 16'h0200, 16'h8000, 0, 0, "R10 reg2");
        fetch(3, 1, 3'd0, 16'h0, 3'd0, 16'h0, 16'h0345, 16'h8000, 0, 0, "R2 imm8");
        fetch(3, 1, 3'd0, 16'h0, 3'd0, 16'h0, 16'h4567, 16'h8000, 2, 0, "R13 imm8 wait states");
        fetch(13, 1, 3'd5, 16'hC123, 3'd0, 16'h0, 16'h0A00, 16'h8000, 1, 0, "R2 imm to mem");
        fetch(4, 1, 3'd0, 16'h0, 3'd0, 16'h0, 16'hFFFF, 16'h8000, 1, 0, "R3 imm16 wrap");
        fetch(5, 1, 3'd1, 16'h0042, 3'd7, 16'h0099, 16'h0100, 16'h8000, 0, 0, "R4 reg to mem C page");
        fetch(6, 1, 3'd0, 16'h0, 3'd1, 16'h0081, 16'h0100, 16'h8000, 2, 0, "R4 load via C page");
        fetch(6, 1, 3'd0, 16'h0, 3'd3, 16'h1281, 16'h0100, 16'h8000, 0, 0, "R4 load plain");
        fetch(7, 1, 3'd4, 16'h0, 3'd4, 16'hFFFF, 16'h0100, 16'hFFFF, 0, 0, "R6 load HL inc wrap");
        fetch(8, 1, 3'd4, 16'h0, 3'd4, 16'h0000, 16'h0100, 16'h0000, 1, 0, "R6 load HL dec wrap");
        fetch(9, 1, 3'd4, 16'h7000, 3'd2, 16'h00EE, 16'h0100, 16'h7000, 0, 0, "R6 store HL inc");
        fetch(10, 1, 3'd4, 16'h7000, 3'd2, 16'h00DD, 16'h0100, 16'h7000, 0, 0, "R6 store HL dec");
        fetch(11, 1, 3'd0, 16'h0, 3'd2, 16'h0077, 16'h0321, 16'h8000, 1, 0, "R5 high-page store");
        fetch(15, 1, 3'd0, 16'h0, 3'd0, 16'h0, 16'h2468, 16'h8000, 0, 1, "R7 R12 abs load, start while busy");
        fetch(12, 1, 3'd0, 16'h0, 3'd2, 16'h0066, 16'h1357, 16'h8000, 2, 0, "R8 abs store");
        fetch(14, 1, 3'd4, 16'h9ABC, 3'd0, 16'h0, 16'h0100, 16'h8000, 0, 0, "R9 read-modify-write");
        fetch(16, 1, 3'd0, 16'h0, 3'd0, 16'h0, 16'h0100, 16'h8000, 0, 0, "R11 illegal 16");
        fetch(3, 1, 3'd0, 16'h0, 3'd0, 16'h0, 16'h0500, 16'h8000, 0, 0, "R11 error stays set");
        fetch(31, 1, 3'd0, 16'h0, 3'd0, 16'h0, 16'h0600, 16'h8000, 0, 0, "R11 illegal 31");
        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0 || done || busy) begin
            fails++;
            $display("FAIL R12 end idle: actual pending=%0d busy=%b expected 0 0", sb.size(), busy);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule